// File: doc/BRIEF.md
# Dual Capture Register Unit

This block snapshots a running counter value into one of two capture registers when a chosen event occurs. The counter itself is outside the block. The block receives the counter's current value and a flag that says whether that value is meaningful. It also receives two already synchronised pins and a strobe from the homing logic. A sync pin edge of selectable polarity, or the homing strobe, loads the first register. A rising edge on a dedicated capture pin loads the second register.

Events are recognised in the same clock cycle in which the external counter sees them. The register is loaded at the same clock edge at which the counter would reset or preset. As a result, the stored value is always the count from before that reset or preset.

The block has two operating modes. In looping (modulo) mode, only the first register works, and it always follows the sync edge. In free-running mode, both registers work, and the first register can instead follow the homing condition. Each register raises a one-cycle strobe whenever it takes a new value.

Top module: `dual_capture_unit`

## Requirements
- R1: While `rst_n` is low, both capture values are 0 and both new-data strobes are 0.
- R2: With `mode_free`=0, a qualified edge on `sync_pin` loads `cap0_val`. The edge is rising when `sync_fall_sel`=0 and falling when it is 1. An edge is a change between the level sampled at the previous clock edge and the present level. `cap0_on_home` has no effect in this mode.
- R3: `cap0_val` never changes while `arm0`=0.
- R4: The value loaded into a register is the `count` present in the cycle of the event, not the value the counter takes after its reset or preset at that same edge.
- R5: With `mode_free`=1 and `arm1`=1, every rising edge of `cap_pin` loads `cap1_val`. While `arm1`=0, `cap1_val` does not change.
- R6: With `mode_free`=0, `cap1_val` never changes, whatever `cap_pin` and `arm1` do.
- R7: With `mode_free`=1 and `cap0_on_home`=1, a high `home_evt` loads `cap0_val`, and sync edges are ignored.
- R8: With `mode_free`=1 and `cap0_on_home`=0, sync edges load `cap0_val`, and `home_evt` is ignored.
- R9: No register loads in a cycle in which `count_ok`=0.
- R10: Each register holds its value until its next qualifying event. Its strobe is high for exactly the one cycle after each load and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count | input | W | Current counter value |
| count_ok | input | 1 | Counter value is valid |
| sync_pin | input | 1 | Synchronised sync pin level |
| sync_fall_sel | input | 1 | 0: rising edge is the sync event, 1: falling edge |
| cap_pin | input | 1 | Synchronised capture pin level |
| home_evt | input | 1 | Homing-condition strobe |
| mode_free | input | 1 | 0: modulo loop mode, 1: free-running mode |
| cap0_on_home | input | 1 | Free mode only: register 0 follows the homing strobe |
| arm0 | input | 1 | Enables register 0 |
| arm1 | input | 1 | Enables register 1 |
| cap0_val | output | W | Capture register 0 |
| cap0_new | output | 1 | One-cycle strobe: register 0 updated |
| cap1_val | output | W | Capture register 1 |
| cap1_new | output | 1 | One-cycle strobe: register 1 updated |

## Verification
An event presented in cycle n shows up at the clock edge that closes cycle n. After that edge, the new value and its strobe are both visible, with no further latency. A pin edge counts from the cycle in which the new level is first sampled. The bench changes inputs on the falling clock edge. A behavioural model updates on each rising edge from the same inputs, and the outputs are compared against it on the following falling edge. Every result is therefore checked one half-period after the edge that should produce it. In the R4 cycles, the bench drives `count` to 0 right after the event, so a late sample would hold 0.

// File: rtl/dual_capture_unit.sv
module dual_capture_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] count,
  input  logic         count_ok,
  input  logic         sync_pin,
  input  logic         sync_fall_sel,
  input  logic         cap_pin,
  input  logic         home_evt,
  input  logic         mode_free,
  input  logic         cap0_on_home,
  input  logic         arm0,
  input  logic         arm1,
  output logic [W-1:0] cap0_val,
  output logic         cap0_new,
  output logic [W-1:0] cap1_val,
  output logic         cap1_new
);
  logic sync_q, cap_q;
  logic sync_edge, cap_rise, src0_evt, take0, take1;

  assign sync_edge = sync_fall_sel ? (sync_q & ~sync_pin) : (~sync_q & sync_pin);
  assign cap_rise  = cap_pin & ~cap_q;
  assign src0_evt  = (mode_free & cap0_on_home) ? home_evt : sync_edge;
  assign take0     = count_ok & arm0 & src0_evt;
  assign take1     = count_ok & arm1 & mode_free & cap_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= 1'b0;
      cap_q    <= 1'b0;
      cap0_val <= '0;
      cap1_val <= '0;
      cap0_new <= 1'b0;
      cap1_new <= 1'b0;
    end else begin
      sync_q   <= sync_pin;
      cap_q    <= cap_pin;
      cap0_new <= take0;
      cap1_new <= take1;
      if (take0) cap0_val <= count;
      if (take1) cap1_val <= count;
    end
  end
endmodule

// File: rtl/dual_capture_unit_chk.sv
module dual_capture_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] count,
  input logic         count_ok,
  input logic         mode_free,
  input logic         arm0,
  input logic         arm1,
  input logic [W-1:0] cap0_val,
  input logic         cap0_new,
  input logic [W-1:0] cap1_val,
  input logic         cap1_new
);
  always_comb if (!rst_n) AST_RESET_CLEAR: assert (cap0_val == '0 && cap1_val == '0 && !cap0_new && !cap1_new); // R1

  AST_CAP0_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !cap0_new |-> $stable(cap0_val)); // R10
  AST_CAP1_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !cap1_new |-> $stable(cap1_val)); // R10
  AST_ARM0_GATE: assert property (@(posedge clk) disable iff (!rst_n) !arm0 |=> !cap0_new); // R3
  AST_ARM1_GATE: assert property (@(posedge clk) disable iff (!rst_n) !arm1 |=> !cap1_new); // R5
  AST_MODULO_NO_CAP1: assert property (@(posedge clk) disable iff (!rst_n) !mode_free |=> !cap1_new); // R6
  AST_VALID_GATE: assert property (@(posedge clk) disable iff (!rst_n) !count_ok |=> (!cap0_new && !cap1_new)); // R9
  AST_CAP0_PRE_VALUE: assert property (@(posedge clk) disable iff (!rst_n) cap0_new |-> cap0_val == $past(count)); // R4
  AST_CAP1_PRE_VALUE: assert property (@(posedge clk) disable iff (!rst_n) cap1_new |-> cap1_val == $past(count)); // R4
endmodule

bind dual_capture_unit dual_capture_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count), .count_ok(count_ok),
  .mode_free(mode_free), .arm0(arm0), .arm1(arm1),
  .cap0_val(cap0_val), .cap0_new(cap0_new),
  .cap1_val(cap1_val), .cap1_new(cap1_new)
);

// File: tb/dual_capture_unit_bench.sv
`timescale 1ns/1ps
module dual_capture_unit_bench;
  localparam int W = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] count = '0;
  logic count_ok = 1'b1, sync_pin = 1'b0, sync_fall_sel = 1'b0, cap_pin = 1'b0;
  logic home_evt = 1'b0, mode_free = 1'b0, cap0_on_home = 1'b0, arm0 = 1'b0, arm1 = 1'b0;
  logic [W-1:0] cap0_val, cap1_val;
  logic cap0_new, cap1_new;

  int checks = 0, errors = 0, cycles = 0;
  string phase = "R1";
  bit done = 0;

  logic [W-1:0] m0, m1;
  logic m0n, m1n, msq, mcq;

  always #4 clk = ~clk;

  dual_capture_unit #(.W(W)) u_dual_capture_unit (.*);

  always @(posedge clk) begin
    if (!rst_n) begin
      m0 = '0; m1 = '0; m0n = 0; m1n = 0; msq = 0; mcq = 0;
    end else begin
      bit se, t0, t1;
      se = sync_fall_sel ? (msq && !sync_pin) : (!msq && sync_pin);
      if (mode_free && cap0_on_home) t0 = count_ok && arm0 && home_evt;
      else t0 = count_ok && arm0 && se;
      t1 = count_ok && arm1 && mode_free && cap_pin && !mcq;
      m0n = t0; m1n = t1;
      if (t0) m0 = count;
      if (t1) m1 = count;
      msq = sync_pin; mcq = cap_pin;
    end
  end

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    cycles++;
    chk(phase, "cap0_val", cap0_val, m0);
    chk(phase, "cap0_new", W'(cap0_new), W'(m0n));
    chk(phase, "cap1_val", cap1_val, m1);
    chk(phase, "cap1_new", W'(cap1_new), W'(m1n));
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin
      @(negedge clk);
      #1 count = count + 1;
    end
  endtask

  initial begin
    count = 32'd100;
    step(3);
    chk("R1", "cap0 in reset", cap0_val, 0);
    chk("R1", "cap1 in reset", cap1_val, 0);
    rst_n = 1; step(2);

    phase = "R2"; arm0 = 1; cap0_on_home = 1;
    sync_pin = 1; step(1); step(3);
    chk("R2", "cap0 rising", cap0_val, m0);
    sync_pin = 0; step(3);
    sync_fall_sel = 1; sync_pin = 1; step(2); sync_pin = 0; step(3);

    phase = "R4"; sync_fall_sel = 0; sync_pin = 1; count = 32'd777;
    @(negedge clk); #1 count = 0; step(2);
    chk("R4", "pre-reset value", cap0_val, 32'd777);
    sync_pin = 0; step(2);

    phase = "R3"; arm0 = 0; sync_pin = 1; step(2); sync_pin = 0; step(2);
    chk("R3", "disarmed hold", cap0_val, 32'd777);
    arm0 = 1;

    phase = "R6"; arm1 = 1; cap_pin = 1; step(2); cap_pin = 0; step(2);
    chk("R6", "modulo cap1", cap1_val, 0);

    phase = "R5"; mode_free = 1; cap0_on_home = 0; cap_pin = 1; count = 32'd555;
    @(negedge clk); #1 count = 32'd3; step(2);
    chk("R5", "cap1 rising", cap1_val, 32'd555);
    cap_pin = 0; step(1); cap_pin = 1; step(1); cap_pin = 0; step(1);
    arm1 = 0; cap_pin = 1; step(2); cap_pin = 0; step(1); arm1 = 1;

    phase = "R8"; home_evt = 1; step(1); home_evt = 0; step(2);
    sync_pin = 1; step(2); sync_pin = 0; step(2);

    phase = "R7"; cap0_on_home = 1; sync_pin = 1; step(2); sync_pin = 0; step(2);
    home_evt = 1; count = 32'd4242; @(negedge clk); #1 home_evt = 0; count = 0; step(2);
    chk("R7", "home capture", cap0_val, 32'd4242);
    home_evt = 1; step(3); home_evt = 0; step(2);

    phase = "R9"; count_ok = 0; home_evt = 1; cap_pin = 1; step(2);
    home_evt = 0; cap_pin = 0; step(2);
    cap0_on_home = 0; sync_pin = 1; step(2); sync_pin = 0; count_ok = 1; step(2);

    phase = "R10"; step(6);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule